// File: doc/BRIEF.md
# Bit-Banged Two-Wire Serial EEPROM Emulator

This block models a 128-byte serial EEPROM that a processor operates by toggling clock and data lines through a single write-only control register. Each register write updates the host's clock level, data level and a read-enable direction flag. The block watches successive writes for start and stop conditions and for clock edges. It accepts a single command byte made of a 7-bit word address and a read/write flag. It then shifts data bytes in or out and hands out or expects acknowledge bits on the ninth clock.

The data line is open-drain. Its level is the host's driven value ANDed with the device's pull-down. A processor read in the window at 0x6000-0x7FFF returns that level on bit 4 while the direction flag is set. All other bits come from a supplied open-bus value. All address and data bits move most significant bit first. The word address steps by one after every byte and wraps from 127 to 0, so multi-byte transfers run through the array.

Top module: `serial_eeprom_emu`

## Requirements
- R1: After reset, the host clock and data levels are both high, the direction flag is clear, and the device drives nothing. A read in the window therefore returns bit 4 = 0 and the open-bus value in every other bit.
- R2: A read with cpu_addr[15:13] = 3'b011 returns open_bus[7:5], the line level on bit 4 when the direction flag (control bit 7) is 1 or 0 when it is 0, and open_bus[3:0]. Any other address returns open_bus unchanged.
- R3: A control write that keeps the clock (bit 5) high and takes data (bit 6) from 1 to 0 is a start and begins a command byte. Keeping the clock high and taking data from 0 to 1 is a stop. A stop abandons any transfer, releases the line and leaves memory untouched by a partial byte.
- R4: After a start, the eight bits sampled on clock rises form the word address (first seven bits, MSB first) and the read/write flag (eighth bit, 1 = read). The device holds the line low from the eighth clock fall until the ninth clock fall.
- R5: In write mode, each group of eight bits, MSB first, is stored at the current address when the eighth clock falls. The device then acknowledges by pulling the line low through the ninth clock.
- R6: In read mode, the device presents the byte at the current address MSB first, changing its output only while the clock is low. It releases the line for the ninth clock.
- R7: The word address increments after each written byte and after each read byte that the host acknowledges, wrapping from 127 to 0.
- R8: If the host leaves the line high on the ninth clock of a read byte, the device stops driving and ignores clock pulses until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control value: bit 7 direction, bit 6 data, bit 5 clock |
| cpu_addr | input | 16 | Processor read address |
| open_bus | input | 8 | Value returned on bits not driven by the block |
| rd_data | output | 8 | Processor read data |

## Verification
The bench aims at the address wrap, with a three-byte write and read starting at 126. A design without wrapping would lose the third byte or read the wrong cell. It also checks bit order through non-palindromic values, since an LSB-first shifter would read back the bit-reversed byte. A stop in the middle of a data byte must not corrupt a cell, which catches a design that commits on every eighth rise instead of on a complete byte. After a host non-acknowledge, further clocks must see a released line; a design that kept reading would pull the line low.

// File: rtl/seep_pkg.sv
package seep_pkg;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BIT_SCL   = 5;
    localparam int BIT_SDA   = 6;
    localparam int BIT_DIR   = 7;
    localparam int BIT_DOUT  = 4;
    localparam logic [2:0] WIN_TAG = 3'b011;
    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_CMD_ACK, PH_WR, PH_WR_ACK, PH_RD, PH_RD_ACK
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    function automatic logic in_window(input logic [15:0] a);
        return a[15:13] == WIN_TAG;
    endfunction
endpackage

// File: rtl/seep_ctrl_port.sv
module seep_ctrl_port
    import seep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic       scl,
    output logic       sda_host,
    output logic       dir,
    output bus_evt_t   evt
);
    logic new_scl, new_sda;
    logic unused_low_bits;

    assign new_scl = wdata[BIT_SCL];
    assign new_sda = wdata[BIT_SDA];
    assign unused_low_bits = ^wdata[4:0];

    always_comb begin
        evt = '0;
        if (we) begin
            evt.start = scl && new_scl && sda_host && !new_sda;
            evt.stop  = scl && new_scl && !sda_host && new_sda;
            evt.rise  = !scl && new_scl;
            evt.fall  = scl && !new_scl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl      <= 1'b1;
            sda_host <= 1'b1;
            dir      <= 1'b0;
        end else if (we) begin
            scl      <= new_scl;
            sda_host <= new_sda;
            dir      <= wdata[BIT_DIR];
        end
    end
endmodule

// File: rtl/seep_store.sv
module seep_store
    import seep_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/seep_fsm.sv
module seep_fsm
    import seep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              scl,
    input  logic              line,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              pull_low
);
    phase_t            ph;
    logic [3:0]        cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] obyte;
    logic [ADDR_W-1:0] addr;
    logic              rw;
    logic              host_ack;
    logic [2:0]        out_idx;
    logic              byte_done;

    assign byte_done = (cnt == BITS_PER_BYTE);
    assign out_idx   = 3'(4'd7 - cnt);
    assign mem_raddr = (ph == PH_RD_ACK) ? addr + 1'b1 : addr;
    assign mem_we    = evt.fall && (ph == PH_WR) && byte_done;
    assign mem_waddr = addr;
    assign mem_wdata = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            obyte    <= '0;
            addr     <= '0;
            rw       <= 1'b0;
            host_ack <= 1'b0;
            pull_low <= 1'b0;
        end else if (evt.start) begin
            ph       <= PH_CMD;
            cnt      <= '0;
            pull_low <= 1'b0;
        end else if (evt.stop) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            pull_low <= 1'b0;
        end else if (evt.rise) begin
            unique case (ph)
                PH_CMD, PH_WR: begin
                    shreg <= {shreg[DATA_W-2:0], line};
                    cnt   <= cnt + 1'b1;
                end
                PH_RD:     cnt <= cnt + 1'b1;
                PH_RD_ACK: host_ack <= !line;
                default: ;
            endcase
        end else if (evt.fall) begin
            unique case (ph)
                PH_CMD: if (byte_done) begin
                    addr     <= shreg[DATA_W-1:1];
                    rw       <= shreg[0];
                    pull_low <= 1'b1;
                    ph       <= PH_CMD_ACK;
                end
                PH_CMD_ACK: begin
                    cnt <= '0;
                    if (rw) begin
                        obyte    <= mem_rdata;
                        pull_low <= !mem_rdata[DATA_W-1];
                        ph       <= PH_RD;
                    end else begin
                        pull_low <= 1'b0;
                        ph       <= PH_WR;
                    end
                end
                PH_WR: if (byte_done) begin
                    addr     <= addr + 1'b1;
                    pull_low <= 1'b1;
                    ph       <= PH_WR_ACK;
                end
                PH_WR_ACK: begin
                    pull_low <= 1'b0;
                    cnt      <= '0;
                    ph       <= PH_WR;
                end
                PH_RD: begin
                    if (byte_done) begin
                        pull_low <= 1'b0;
                        ph       <= PH_RD_ACK;
                    end else begin
                        pull_low <= !obyte[out_idx];
                    end
                end
                PH_RD_ACK: begin
                    cnt <= '0;
                    if (host_ack) begin
                        addr     <= addr + 1'b1;
                        obyte    <= mem_rdata;
                        pull_low <= !mem_rdata[DATA_W-1];
                        ph       <= PH_RD;
                    end else begin
                        pull_low <= 1'b0;
                        ph       <= PH_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    p_cmd_ack_low_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_CMD_ACK) |-> pull_low);

    p_drive_on_low_clock_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_low) |-> !scl);

    p_stop_releases_r3: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (ph == PH_IDLE && !pull_low));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE) |-> !pull_low);

    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/serial_eeprom_emu.sv
module serial_eeprom_emu
    import seep_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_we,
    input  logic [7:0]  ctrl_wdata,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  open_bus,
    output logic [7:0]  rd_data
);
    bus_evt_t          evt;
    logic              scl, sda_host, dir, line, pull_low;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_raddr, mem_waddr;
    logic [DATA_W-1:0] mem_rdata, mem_wdata;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^cpu_addr[12:0];
    assign line = sda_host & ~pull_low;

    seep_ctrl_port u_port (
        .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata),
        .scl(scl), .sda_host(sda_host), .dir(dir), .evt(evt)
    );

    seep_fsm u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .scl(scl), .line(line),
        .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .pull_low(pull_low)
    );

    seep_store u_store (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    always_comb begin
        rd_data = open_bus;
        if (in_window(cpu_addr)) rd_data[BIT_DOUT] = dir & line;
    end
endmodule

// File: tb/test_serial_eeprom_emu.sv
module test_serial_eeprom_emu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = 8'h60;
    logic [15:0] cpu_addr = 16'h6000;
    logic [7:0]  open_bus = 8'b1110_1011;
    logic [7:0]  rd_data;
    logic        dir = 1'b1;
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    serial_eeprom_emu i_serial_eeprom_emu (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cpu_addr(cpu_addr), .open_bus(open_bus), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; failures++;
            $display("FAIL watchdog R1 act=%0d exp=<150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic scl, input logic sda);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = {dir, sda, scl, 5'b0};
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic line_level(output logic b);
        cpu_addr = 16'h6000;
        #1 b = rd_data[4];
    endtask

    task automatic start_cond();
        wr(1, 1); wr(1, 0); wr(0, 0);
    endtask

    task automatic stop_cond();
        wr(0, 0); wr(1, 0); wr(1, 1);
    endtask

    task automatic send_bit(input logic b);
        wr(0, b); wr(1, b); wr(0, b);
    endtask

    task automatic sample_bit(output logic b);
        wr(0, 1); wr(1, 1); line_level(b); wr(0, 1);
    endtask

    task automatic tx_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sample_bit(b);
        ack = !b;
    endtask

    task automatic rx_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            sample_bit(b);
            v[i] = b;
        end
        send_bit(!give_ack);
    endtask

    task automatic write_seq(input logic [6:0] a, input int n, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        start_cond();
        tx_byte({a, 1'b0}, ack);
        check(ack, "R4 command ack (write)", ack, 1);
        for (int i = 0; i < n; i++) begin
            tx_byte(d[i], ack);
            check(ack, "R5 data byte ack", ack, 1);
        end
        stop_cond();
    endtask

    task automatic read_seq(input logic [6:0] a, input int n, input logic [7:0] e0,
                            input logic [7:0] e1, input logic [7:0] e2, input string req);
        logic ack;
        logic [7:0] v;
        logic [7:0] e [3];
        e[0] = e0; e[1] = e1; e[2] = e2;
        start_cond();
        tx_byte({a, 1'b1}, ack);
        check(ack, "R4 command ack (read)", ack, 1);
        for (int i = 0; i < n; i++) begin
            rx_byte(i != n - 1, v);
            check(v == e[i], req, v, e[i]);
        end
        stop_cond();
    endtask

    task automatic t_reset();
        dir = 1'b0;
        cpu_addr = 16'h6000;
        #1 check(rd_data == 8'b1110_1011, "R1 reset read with direction clear", rd_data, 8'hEB);
        wr(1, 1);
        cpu_addr = 16'h7FFF;
        #1 check(rd_data == 8'hEB, "R2 direction clear masks bit 4", rd_data, 8'hEB);
        dir = 1'b1;
        wr(1, 1);
        #1 check(rd_data == 8'hFB, "R2 idle line high on bit 4", rd_data, 8'hFB);
        cpu_addr = 16'h8000;
        #1 check(rd_data == 8'hEB, "R2 outside window is open bus", rd_data, 8'hEB);
        open_bus = 8'h04;
        cpu_addr = 16'h6123;
        #1 check(rd_data == 8'h14, "R2 other bits follow open bus", rd_data, 8'h14);
        open_bus = 8'hEB;
    endtask

    task automatic t_single();
        write_seq(7'd5, 1, 8'hA6, 8'h00, 8'h00);
        read_seq(7'd5, 1, 8'hA6, 8'h00, 8'h00, "R6 single byte MSB first");
    endtask

    task automatic t_wrap();
        write_seq(7'd126, 3, 8'h13, 8'h2C, 8'h71);
        read_seq(7'd127, 1, 8'h2C, 8'h00, 8'h00, "R7 byte at 127");
        read_seq(7'd0, 1, 8'h71, 8'h00, 8'h00, "R7 wrap write to 0");
        read_seq(7'd126, 3, 8'h13, 8'h2C, 8'h71, "R7 sequential read with wrap");
    endtask

    task automatic t_nack();
        logic ack, b;
        logic [7:0] v;
        write_seq(7'd20, 2, 8'h00, 8'h00, 8'h00);
        start_cond();
        tx_byte({7'd20, 1'b1}, ack);
        rx_byte(1'b0, v);
        check(v == 8'h00, "R8 byte before nack", v, 8'h00);
        for (int i = 0; i < 9; i++) begin
            sample_bit(b);
            check(b == 1'b1, "R8 line released after nack", b, 1);
        end
        stop_cond();
        read_seq(7'd21, 1, 8'h00, 8'h00, 8'h00, "R8 start works after nack");
    endtask

    task automatic t_stop_abort();
        logic ack, b;
        write_seq(7'd9, 1, 8'h3C, 8'h00, 8'h00);
        start_cond();
        tx_byte({7'd9, 1'b0}, ack);
        send_bit(1); send_bit(1); send_bit(1); send_bit(1);
        stop_cond();
        read_seq(7'd9, 1, 8'h3C, 8'h00, 8'h00, "R3 partial byte discarded by stop");
        start_cond();
        send_bit(0); send_bit(0); send_bit(0);
        stop_cond();
        for (int i = 0; i < 9; i++) begin
            sample_bit(b);
            check(b == 1'b1, "R3 no ack after aborted command", b, 1);
        end
        read_seq(7'd9, 1, 8'h3C, 8'h00, 8'h00, "R3 fresh start after stop");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_wrap();
        t_nack();
        t_stop_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule